// File: doc/BRIEF.md
# Translation Attribute Resolver and Formatter

This block takes the leaf-descriptor attribute field of one long-descriptor translation stage and works out the memory attributes of the access. The result is an 8-bit cache-attribute byte and a 2-bit shareability code. It then packs them with the physical address, the security state and the fault outcome into the 64-bit word that an address-translation request returns.

The cache byte has one of two sources, chosen by a stage flag:

- **Stage 1:** the byte is an indexed lane of a 64-bit attribute-indirection register.
- **Stage 2:** a 4-bit direct attribute field is widened to a full byte, and default allocation hints are filled in.

A failed translation produces a word that carries only the fault flag and the fault status. Each valid request produces a registered result one cycle later.

Top module: `xlat_result_fmt`

## Requirements
- R1: For stage 1 (`stage2_in`=0), the cache byte is bits [8*k+7:8*k] of `indir_in`, where k is `desc_in[2:0]`.
- R2: For both stages, the shareability code is `desc_in[7:6]`. Bits `desc_in[5:4]` have no effect on the result word.
- R3: For stage 2, `desc_in[3:2]` become cache-byte bits [7:6] and `desc_in[1:0]` become cache-byte bits [3:2].
- R4: For stage 2, hint bits are filled in as follows:
  - When `desc_in[3:2]`=00 (device), both hint pairs (bits [5:4] and [1:0]) are 00.
  - Otherwise each nibble whose type bits are 01 (non-cacheable) gets hints 00.
  - Every other nibble gets hints 11.
- R5: On success (`fault_in`=0), the result word has the cache byte at [63:56], shareability at [8:7], `ns_in` at [9], `pa_in[47:12]` at [47:12], and bit 0 clear.
- R6: On a fault, bit 0 is 1 and `fsc_in` is at [6:1]. Every other bit is 0, whatever the attribute, address and security inputs are.
- R7: On success, result bits [55:48], [11:10] and [6:1] are 0.
- R8: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high. `res_word` is loaded only on valid input and holds otherwise.
- R9: A synchronous active-low reset (`rst_n`) clears `res_valid` and `res_word` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| stage2_in | input | 1 | 1 selects the stage-2 attribute encoding |
| desc_in | input | 8 | Descriptor attribute field |
| indir_in | input | 64 | Attribute-indirection register, eight byte lanes |
| pa_in | input | 48 | Translated physical address |
| ns_in | input | 1 | Access is non-secure |
| fault_in | input | 1 | Translation failed |
| fsc_in | input | 6 | Fault status code |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_word | output | 64 | Packed translation result |

## Verification
The assertions assume that every input is stable and known across the clock edge at which `in_valid` is sampled. They make no assumption about input values while `in_valid` is low, because the result register ignores them.

The bench meets this by changing inputs only at falling edges and by dropping `in_valid` after each request. Over the bench, the descriptor field covers all eight lane indices, all sixteen stage-2 codes and both values of the permission bits.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
  localparam int RES_W   = 64;
  localparam int ATTR_W  = 8;
  localparam int SHARE_W = 2;

  typedef struct packed {
    logic [ATTR_W-1:0]  cattr;
    logic [SHARE_W-1:0] share;
  } mem_attr_t;

  // Allocation hints for one widened stage-2 nibble.
  // Device outer forces 00; non-cacheable (type 01) gets 00; WT/WB get 11.
  function automatic logic [1:0] s2_hint(input logic [1:0] ty, input logic device);
    if (device)          s2_hint = 2'b00;
    else if (ty == 2'b01) s2_hint = 2'b00;
    else                 s2_hint = 2'b11;
  endfunction

  // Widen a 4-bit stage-2 memory attribute into a full cache byte.
  function automatic logic [ATTR_W-1:0] s2_widen(input logic [3:0] mattr);
    logic dev;
    dev = (mattr[3:2] == 2'b00);
    s2_widen = {mattr[3:2], s2_hint(mattr[3:2], dev),
                mattr[1:0], s2_hint(mattr[1:0], dev)};
  endfunction
endpackage

// File: rtl/xrf_lane_pick.sv
module xrf_lane_pick #(
  parameter int IND_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = IND_W / LANE_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [IND_W-1:0]  indir,
  input  logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane
);
  logic [LANE_W-1:0] lane_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_arr[g] = indir[g*LANE_W +: LANE_W];
  end

  assign lane = lane_arr[idx];
endmodule

// File: rtl/xrf_s2_widen.sv
module xrf_s2_widen
  import xrf_pkg::*;
(
  input  logic [3:0]        mattr,
  output logic [ATTR_W-1:0] cattr
);
  always_comb cattr = s2_widen(mattr);
endmodule

// File: rtl/xrf_pack.sv
module xrf_pack
  import xrf_pkg::*;
#(
  parameter int PA_W  = 48,
  parameter int FSC_W = 6,
  localparam int PG_LSB   = 12,
  localparam int ATTR_LSB = RES_W - ATTR_W,
  localparam int SH_LSB   = 7,
  localparam int NS_BIT   = 9
) (
  input  mem_attr_t          attr,
  input  logic [PA_W-1:0]    pa,
  input  logic               ns,
  input  logic               fault,
  input  logic [FSC_W-1:0]   fsc,
  output logic [RES_W-1:0]   word
);
  logic [PG_LSB-1:0] unused_pa_low;
  assign unused_pa_low = pa[PG_LSB-1:0];

  always_comb begin
    word = '0;
    if (fault) begin
      word[0]       = 1'b1;
      word[FSC_W:1] = fsc;
    end else begin
      word[RES_W-1:ATTR_LSB]        = attr.cattr;
      word[PA_W-1:PG_LSB]           = pa[PA_W-1:PG_LSB];
      word[NS_BIT]                  = ns;
      word[SH_LSB+SHARE_W-1:SH_LSB] = attr.share;
    end
  end
endmodule

// File: rtl/xlat_result_fmt.sv
module xlat_result_fmt
  import xrf_pkg::*;
#(
  parameter int PA_W   = 48,
  parameter int DESC_W = 8,
  parameter int IND_W  = 64,
  parameter int FSC_W  = 6,
  localparam int IDX_W = $clog2(IND_W / ATTR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              stage2_in,
  input  logic [DESC_W-1:0] desc_in,
  input  logic [IND_W-1:0]  indir_in,
  input  logic [PA_W-1:0]   pa_in,
  input  logic              ns_in,
  input  logic              fault_in,
  input  logic [FSC_W-1:0]  fsc_in,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_word
);
  logic [ATTR_W-1:0] s1_byte, s2_byte;
  mem_attr_t         attr_sel;
  logic [RES_W-1:0]  word_next;
  logic [1:0]        unused_perm;

  assign unused_perm = desc_in[5:4];

  xrf_lane_pick #(.IND_W(IND_W), .LANE_W(ATTR_W)) u_pick (
    .indir(indir_in), .idx(desc_in[IDX_W-1:0]), .lane(s1_byte)
  );

  xrf_s2_widen u_widen (.mattr(desc_in[3:0]), .cattr(s2_byte));

  always_comb begin
    attr_sel.cattr = stage2_in ? s2_byte : s1_byte;
    attr_sel.share = desc_in[DESC_W-1:DESC_W-2];
  end

  xrf_pack #(.PA_W(PA_W), .FSC_W(FSC_W)) u_pack (
    .attr(attr_sel), .pa(pa_in), .ns(ns_in), .fault(fault_in),
    .fsc(fsc_in), .word(word_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_word <= word_next;
    end
  end

  // Named probes for the assertions: shift-based lane pick and event wires
  logic [ATTR_W-1:0] probe_s1;
  logic              ev_ok_s1, ev_ok_s2, ev_fault;
  assign probe_s1 = ATTR_W'(indir_in >> {desc_in[IDX_W-1:0], 3'b000});
  assign ev_ok_s1 = in_valid && !fault_in && !stage2_in;
  assign ev_ok_s2 = in_valid && !fault_in && stage2_in;
  assign ev_fault = in_valid && fault_in;

  AST_S1_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok_s1 |=> res_word[63:56] == $past(probe_s1)); // R1
  AST_SHARE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fault_in) |=> res_word[8:7] == $past(desc_in[7:6])); // R2
  AST_S2_TYPES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok_s2 |=> (res_word[63:62] == $past(desc_in[3:2]) &&
                  res_word[59:58] == $past(desc_in[1:0]))); // R3
  AST_S2_NC_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok_s2 && desc_in[3:2] == 2'b01) |=> res_word[61:60] == 2'b00); // R4
  AST_S2_DEV_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok_s2 && desc_in[3:2] == 2'b00) |=>
      (res_word[61:60] == 2'b00 && res_word[57:56] == 2'b00)); // R4
  AST_OK_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fault_in) |=> (!res_word[0] && res_word[9] == $past(ns_in) &&
      res_word[47:12] == $past(pa_in[47:12]))); // R5
  AST_FAULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (res_word[0] && res_word[6:1] == $past(fsc_in) &&
                  res_word[63:7] == '0)); // R6
  AST_OK_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fault_in) |=> (res_word[55:48] == '0 &&
      res_word[11:10] == '0 && res_word[6:1] == '0)); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R8
  AST_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_word))); // R8
endmodule

// File: tb/xlat_result_fmt_test.sv
`timescale 1ns/1ps
module xlat_result_fmt_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, stage2_in = 0, ns_in = 0, fault_in = 0;
  logic [7:0]  desc_in = 0;
  logic [63:0] indir_in = 0;
  logic [47:0] pa_in = 0;
  logic [5:0]  fsc_in = 0;
  logic        res_valid;
  logic [63:0] res_word;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlat_result_fmt uut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_s2(logic [3:0] m);
    logic [3:0] hi, lo;
    if (m[3:2] == 2'b00) begin
      hi = 4'h0; lo = {m[1:0], 2'b00};
    end else begin
      hi = (m[3:2] == 2'b01) ? 4'h4 : {m[3:2], 2'b11};
      lo = (m[1:0] == 2'b01) ? 4'h4 : {m[1:0], 2'b11};
    end
    return {hi, lo};
  endfunction

  function automatic logic [63:0] exp_word(logic s2, logic [7:0] d, logic [63:0] ind,
      logic [47:0] pa, logic ns, logic f, logic [5:0] fs);
    logic [63:0] w;
    logic [7:0] c;
    w = 64'd0;
    if (f) begin
      w = {57'd0, fs, 1'b1};
    end else begin
      c = s2 ? exp_s2(d[3:0]) : ind[d[2:0]*8 +: 8];
      w = {c, 8'd0, pa[47:12], 2'b00, ns, d[7:6], 7'd0};
    end
    return w;
  endfunction

  task automatic xfer(string req, logic s2, logic [7:0] d, logic [63:0] ind,
      logic [47:0] pa, logic ns, logic f, logic [5:0] fs);
    @(negedge clk);
    stage2_in = s2; desc_in = d; indir_in = ind; pa_in = pa;
    ns_in = ns; fault_in = f; fsc_in = fs; in_valid = 1;
    @(posedge clk); #1;
    check({req, " valid"}, {63'd0, res_valid}, 64'd1);
    check(req, res_word, exp_word(s2, d, ind, pa, ns, f, fs));
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset valid", {63'd0, res_valid}, 64'd0);
    check("R9 reset word", res_word, 64'd0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_stage1();
    for (int k = 0; k < 8; k++)
      xfer("R1 stage1 lane", 0, {2'(k), 3'b000, 3'(k)}, 64'h1122334455667788,
           48'h0000_1234_5000, 0, 0, 6'd0);
  endtask

  task automatic t_share();
    for (int p = 0; p < 4; p++)
      xfer("R2 perm bits ignored", 1, {2'b11, 2'(p), 4'b1111}, 64'd0,
           48'hABCD_EF01_2000, 1, 0, 6'd0);
    xfer("R2 share 10", 0, 8'b10_11_0101, 64'hFF00FF00FF00FF00, 48'h1000, 0, 0, 0);
  endtask

  task automatic t_stage2();
    for (int m = 0; m < 16; m++)
      xfer("R3 R4 stage2 widen", 1, {4'b0100, 4'(m)}, 64'hFFFF_FFFF_FFFF_FFFF,
           48'h8000_0000_0000, 0, 0, 6'd0);
  endtask

  task automatic t_layout();
    xfer("R5 R7 ns set", 0, 8'h05, 64'hA5A5_5A5A_C3C3_3C3C, 48'hFFFF_FFFF_FFFF, 1, 0, 0);
    xfer("R5 R7 ns clear", 0, 8'h02, 64'h0, 48'h5555_5555_5FFF, 0, 0, 0);
  endtask

  task automatic t_fault();
    xfer("R6 fault", 0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1, 1, 6'h2A);
    xfer("R6 fault s2", 1, 8'hC7, 64'h1234, 48'h1234_5678_9000, 0, 1, 6'h3F);
  endtask

  task automatic t_hold();
    logic [63:0] last;
    xfer("R8 load", 0, 8'h43, 64'h0011_2233_4455_6677, 48'h0000_0000_F000, 1, 0, 0);
    last = res_word;
    @(negedge clk);
    stage2_in = 1; desc_in = 8'hFF; pa_in = 48'h0; fault_in = 1; fsc_in = 6'h11;
    @(posedge clk); #1;
    check("R8 no valid without request", {63'd0, res_valid}, 64'd0);
    check("R8 word held", res_word, last);
  endtask

  task automatic t_reset_mid();
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R9 mid reset valid", {63'd0, res_valid}, 64'd0);
    check("R9 mid reset word", res_word, 64'd0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_stage1();
    t_share();
    t_stage2();
    t_layout();
    t_fault();
    t_hold();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule